// File: doc/BRIEF.md
# Direct Digital Synthesis Modulator Core

This block is a numerically controlled oscillator with frequency, phase and quadrature amplitude modulation. It holds two frequency tuning words and picks one of them on every clock to advance a phase accumulator. The result is the accumulator's top bits plus a phase offset. A synthesizable quarter-wave table turns that phase into signed sine and cosine samples. The output is either the cosine sample or the weighted sum of an in-phase and a quadrature amplitude factor times cosine and sine. This value is presented as an offset-binary code for a digital-to-analog converter.

Register contents come from a separate transfer controller as already-decoded one-cycle load strobes that share a single data bus. Sleep can be requested on a pin or through a command register bit. While asleep, the datapath stops and the output sits at mid-scale.

The output code has no handshake. A converter consumes one code on every clock, so there is no back-pressure. The code is valid on every cycle: during reset and sleep it is mid-scale, and at all other times it is the pipeline's result. The frequency select input is sampled on every rising edge.

Top module: `dds_mod_core`

## Requirements
- R1: On each running clock edge the 32-bit accumulator adds word 0 when `fsel` is 0, or word 1 when `fsel` is 1, modulo 2^32. The choice may change on every cycle.
- R2: A high load strobe at a clock edge writes `ld_data` into its register at that edge, and this includes edges in sleep. Field positions are:
  - both frequency words use bits [31:0];
  - the phase offset uses bits [11:0];
  - the in-phase factor I uses bits [9:0] and the quadrature factor Q uses bits [19:10], both signed two's complement;
  - the command register uses bit 0 for amplitude modulation enable and bit 1 for sleep.
- R3: The table phase is (accumulator bits [31:20] + phase offset) mod 4096.
- R4: For a 12-bit phase p, the quadrant is p[11:10] and the index is x = p[9:0]. Define q(x) = floor((2044·x·(2048−x) + D/2) / D) with D = 5·2^20 − x·(2048−x), using integer division for D/2. The index used is x in quadrants 0 and 2 and 1024−x in quadrants 1 and 3. The sine is +q in quadrants 0 and 1 and −q in quadrants 2 and 3. The cosine of p is the sine of (p+1024) mod 4096.
- R5: With modulation disabled, the code is cosine + 512.
- R6: With modulation enabled, the code is floor((I·cos + Q·sin + 256) / 512) + 512, after saturation.
- R7: A code reflects the accumulator value held three running clock edges earlier.
- R8: While `sleep_pin` or the command sleep bit is high at an edge, the accumulator and pipeline hold, and the code after that edge is 512.
- R9: A synchronous active-high `rst` clears both frequency words, the phase offset, I, Q, the command register, the accumulator and the pipeline. The code is 512 after a reset edge, and loads are ignored during reset.
- R10: The modulated value saturates to the range [−512, 511], so the code stays in [0, 1023].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesis clock |
| rst | input | 1 | Synchronous reset, active high |
| sleep_pin | input | 1 | External sleep request, active high |
| fsel | input | 1 | Selects frequency word 1 when high |
| ld_freq0 | input | 1 | Load strobe, frequency word 0 |
| ld_freq1 | input | 1 | Load strobe, frequency word 1 |
| ld_phase | input | 1 | Load strobe, phase offset |
| ld_iq | input | 1 | Load strobe, I and Q factors |
| ld_cmd | input | 1 | Load strobe, command register |
| ld_data | input | 32 | Shared load data |
| dac_code | output | 10 | Offset-binary converter code |

## Verification
The assertions assume the following about the inputs:
- Every input is driven to a known level on each clock edge from reset on.
- Load strobes are only meaningful outside reset.
- `rst` is asserted at the first edge.

The bench drives all inputs at the falling edge. It holds `rst` high for the first edges and never leaves a pin floating. Frequency words, select, sleep and the modulation factors are randomized with a fixed seed inside their legal encodings. Directed cases cover 45-degree saturation in both directions, loads made during sleep, and reset in the middle of a run.

// File: rtl/dds_pkg.sv
package dds_pkg;

  localparam int CMD_AM_BIT    = 0;
  localparam int CMD_SLEEP_BIT = 1;

  // Rational approximation of amp*sin(pi*x/(2*qlen)) for 0 <= x <= qlen,
  // exact at both ends, rounded to nearest.
  function automatic int quarter_amp(input int x, input int qlen, input int amp);
    longint p;
    longint d;
    p = longint'(x) * longint'(2 * qlen - x);
    d = longint'(5) * longint'(qlen) * longint'(qlen) - p;
    return int'((longint'(4 * amp) * p + d / 2) / d);
  endfunction

endpackage

// File: rtl/dds_regs.sv
module dds_regs #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int SMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_freq0,
  input  logic                    ld_freq1,
  input  logic                    ld_phase,
  input  logic                    ld_iq,
  input  logic                    ld_cmd,
  input  logic [ACC_W-1:0]        ld_data,
  output logic [ACC_W-1:0]        freq0,
  output logic [ACC_W-1:0]        freq1,
  output logic [PH_W-1:0]         ph_off,
  output logic signed [SMP_W-1:0] i_amp,
  output logic signed [SMP_W-1:0] q_amp,
  output logic                    am_en,
  output logic                    cmd_sleep
);
  import dds_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      freq0     <= '0;
      freq1     <= '0;
      ph_off    <= '0;
      i_amp     <= '0;
      q_amp     <= '0;
      am_en     <= 1'b0;
      cmd_sleep <= 1'b0;
    end else begin
      if (ld_freq0) freq0 <= ld_data;
      if (ld_freq1) freq1 <= ld_data;
      if (ld_phase) ph_off <= ld_data[PH_W-1:0];
      if (ld_iq) begin
        i_amp <= signed'(ld_data[SMP_W-1:0]);
        q_amp <= signed'(ld_data[2*SMP_W-1:SMP_W]);
      end
      if (ld_cmd) begin
        am_en     <= ld_data[CMD_AM_BIT];
        cmd_sleep <= ld_data[CMD_SLEEP_BIT];
      end
    end
  end
endmodule

// File: rtl/dds_phase.sv
module dds_phase #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             fsel,
  input  logic [ACC_W-1:0] freq0,
  input  logic [ACC_W-1:0] freq1,
  input  logic [PH_W-1:0]  ph_off,
  output logic [ACC_W-1:0] acc,
  output logic [PH_W-1:0]  phase
);
  logic [ACC_W-1:0] step;

  assign step  = fsel ? freq1 : freq0;
  assign phase = acc[ACC_W-1 -: PH_W] + ph_off;

  always_ff @(posedge clk) begin
    if (rst)      acc <= '0;
    else if (run) acc <= acc + step;
  end
endmodule

// File: rtl/dds_sincos.sv
module dds_sincos #(
  parameter int PH_W  = 12,
  parameter int SMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic [PH_W-1:0]         phase,
  output logic signed [SMP_W-1:0] sin_s,
  output logic signed [SMP_W-1:0] cos_s
);
  import dds_pkg::*;

  localparam int QLEN = 2 ** (PH_W - 2);
  localparam int AMP  = 2 ** (SMP_W - 1) - 1;

  logic [SMP_W-2:0] tab [0:QLEN];

  for (genvar g = 0; g <= QLEN; g++) begin : g_tab
    assign tab[g] = (SMP_W-1)'(quarter_amp(g, QLEN, AMP));
  end

  // channel 0 is sine, channel 1 is the sine a quarter turn ahead (cosine)
  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [PH_W-1:0]         p;
    logic [PH_W-3:0]         idx;
    logic [PH_W-2:0]         mi;
    logic signed [SMP_W-1:0] mag;
    logic signed [SMP_W-1:0] val;
    logic signed [SMP_W-1:0] smp_q;

    assign p   = phase + PH_W'(ch * QLEN);
    assign idx = p[PH_W-3:0];
    assign mi  = p[PH_W-2] ? ((PH_W-1)'(QLEN) - {1'b0, idx}) : {1'b0, idx};
    assign mag = signed'({1'b0, tab[mi]});
    assign val = p[PH_W-1] ? -mag : mag;

    always_ff @(posedge clk) begin
      if (rst)      smp_q <= '0;
      else if (run) smp_q <= val;
    end
  end

  assign sin_s = g_ch[0].smp_q;
  assign cos_s = g_ch[1].smp_q;
endmodule

// File: rtl/dds_amod.sv
module dds_amod #(
  parameter int SMP_W = 10
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    run,
  input  logic                    am_en,
  input  logic signed [SMP_W-1:0] i_amp,
  input  logic signed [SMP_W-1:0] q_amp,
  input  logic signed [SMP_W-1:0] sin_s,
  input  logic signed [SMP_W-1:0] cos_s,
  output logic [SMP_W-1:0]        dac_code
);
  localparam int PW = 2 * SMP_W;
  localparam int SW = PW + 1;
  localparam logic [SMP_W-1:0]     MID = SMP_W'(1) << (SMP_W - 1);
  localparam logic signed [SW-1:0] RND = SW'(1) <<< (SMP_W - 2);
  localparam logic signed [SW-1:0] HI  = SW'((1 << (SMP_W - 1)) - 1);
  localparam logic signed [SW-1:0] LO  = -HI - SW'(1);

  logic signed [PW-1:0]    prod_i, prod_q;
  logic signed [SMP_W-1:0] cos_b;
  logic signed [SW-1:0]    sum, scaled;
  logic signed [SMP_W-1:0] am_val, sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_i <= '0;
      prod_q <= '0;
      cos_b  <= '0;
    end else if (run) begin
      prod_i <= i_amp * cos_s;
      prod_q <= q_amp * sin_s;
      cos_b  <= cos_s;
    end
  end

  always_comb begin
    sum    = SW'(prod_i) + SW'(prod_q);
    scaled = (sum + RND) >>> (SMP_W - 1);
    if (scaled > HI)      am_val = HI[SMP_W-1:0];
    else if (scaled < LO) am_val = LO[SMP_W-1:0];
    else                  am_val = scaled[SMP_W-1:0];
    sel = am_en ? am_val : cos_b;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) dac_code <= MID;
    else             dac_code <= {~sel[SMP_W-1], sel[SMP_W-2:0]};
  end
endmodule

// File: rtl/dds_mod_core.sv
module dds_mod_core #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int SMP_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_pin,
  input  logic             fsel,
  input  logic             ld_freq0,
  input  logic             ld_freq1,
  input  logic             ld_phase,
  input  logic             ld_iq,
  input  logic             ld_cmd,
  input  logic [ACC_W-1:0] ld_data,
  output logic [SMP_W-1:0] dac_code
);
  logic [ACC_W-1:0]        f0_w, f1_w, acc_w;
  logic [PH_W-1:0]         poff_w, phase_w;
  logic signed [SMP_W-1:0] i_w, q_w, sin_w, cos_w;
  logic                    am_w, csleep_w, run_w;

  assign run_w = ~(sleep_pin | csleep_w);

  dds_regs #(.ACC_W(ACC_W), .PH_W(PH_W), .SMP_W(SMP_W)) u_regs (
    .clk(clk), .rst(rst),
    .ld_freq0(ld_freq0), .ld_freq1(ld_freq1), .ld_phase(ld_phase),
    .ld_iq(ld_iq), .ld_cmd(ld_cmd), .ld_data(ld_data),
    .freq0(f0_w), .freq1(f1_w), .ph_off(poff_w),
    .i_amp(i_w), .q_amp(q_w), .am_en(am_w), .cmd_sleep(csleep_w)
  );

  dds_phase #(.ACC_W(ACC_W), .PH_W(PH_W)) u_phase (
    .clk(clk), .rst(rst), .run(run_w), .fsel(fsel),
    .freq0(f0_w), .freq1(f1_w), .ph_off(poff_w),
    .acc(acc_w), .phase(phase_w)
  );

  dds_sincos #(.PH_W(PH_W), .SMP_W(SMP_W)) u_sincos (
    .clk(clk), .rst(rst), .run(run_w), .phase(phase_w),
    .sin_s(sin_w), .cos_s(cos_w)
  );

  dds_amod #(.SMP_W(SMP_W)) u_amod (
    .clk(clk), .rst(rst), .run(run_w), .am_en(am_w),
    .i_amp(i_w), .q_amp(q_w), .sin_s(sin_w), .cos_s(cos_w),
    .dac_code(dac_code)
  );
endmodule

// File: rtl/dds_mod_core_chk.sv
module dds_mod_core_chk #(
  parameter int ACC_W = 32,
  parameter int PH_W  = 12,
  parameter int SMP_W = 10
) (
  input logic               clk,
  input logic               rst,
  input logic               sleep_pin,
  input logic               cmd_sleep,
  input logic               fsel,
  input logic               ld_iq,
  input logic [ACC_W-1:0]   freq0,
  input logic [ACC_W-1:0]   freq1,
  input logic [ACC_W-1:0]   acc,
  input logic [PH_W-1:0]    ph_off,
  input logic [2*SMP_W-1:0] iq_word,
  input logic [SMP_W-1:0]   dac_code
);
  localparam logic [SMP_W-1:0] MID = SMP_W'(1) << (SMP_W - 1);

  p_sleep_mid_r8: assert property (@(posedge clk) disable iff (rst)
    (sleep_pin || cmd_sleep) |=> dac_code == MID);

  p_acc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (sleep_pin || cmd_sleep) |=> $stable(acc));

  p_acc_step_r1: assert property (@(posedge clk) disable iff (rst)
    !(sleep_pin || cmd_sleep) |=>
      acc == $past(acc) + ($past(fsel) ? $past(freq1) : $past(freq0)));

  p_reset_clear_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (freq0 == '0 && freq1 == '0 && acc == '0 && ph_off == '0
                    && iq_word == '0 && !cmd_sleep && dac_code == MID));

  p_iq_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !ld_iq |=> $stable(iq_word));
endmodule

bind dds_mod_core dds_mod_core_chk #(.ACC_W(ACC_W), .PH_W(PH_W), .SMP_W(SMP_W)) u_chk (
  .clk(clk), .rst(rst), .sleep_pin(sleep_pin), .cmd_sleep(csleep_w),
  .fsel(fsel), .ld_iq(ld_iq), .freq0(f0_w), .freq1(f1_w), .acc(acc_w),
  .ph_off(poff_w), .iq_word({q_w, i_w}), .dac_code(dac_code)
);

// File: tb/sim_dds_mod_core.sv
module sim_dds_mod_core;
  logic        clk = 1'b0;
  logic        rst, sleep_pin, fsel;
  logic        ld_freq0, ld_freq1, ld_phase, ld_iq, ld_cmd;
  logic [31:0] ld_data;
  logic [9:0]  dac_code;

  always #5 clk = ~clk;

  dds_mod_core u0 (
    .clk(clk), .rst(rst), .sleep_pin(sleep_pin), .fsel(fsel),
    .ld_freq0(ld_freq0), .ld_freq1(ld_freq1), .ld_phase(ld_phase),
    .ld_iq(ld_iq), .ld_cmd(ld_cmd), .ld_data(ld_data), .dac_code(dac_code)
  );

  int n_chk = 0;
  int n_bad = 0;

  bit [31:0] m_f0, m_f1, m_acc;
  int        m_poff, m_i, m_q;
  bit        m_am, m_csl;
  int        m_a, m_b, m_c;
  int        settle;

  function automatic int qamp(int x);
    longint p, d;
    p = longint'(x) * longint'(2048 - x);
    d = 64'd5242880 - p;
    return int'((2044 * p + d / 2) / d);
  endfunction

  function automatic int sine(int ph);
    int p, quad, x, m;
    p    = ph & 4095;
    quad = p >> 10;
    x    = p & 1023;
    m    = (quad % 2 == 1) ? qamp(1024 - x) : qamp(x);
    return (quad >= 2) ? -m : m;
  endfunction

  function automatic int expect_code(bit [31:0] acc);
    int ph, s, c, v, r;
    ph = int'(acc >> 20) + m_poff;
    s  = sine(ph);
    c  = sine(ph + 1024);
    if (!m_am) return c + 512;
    v = m_i * c + m_q * s;
    r = (v + 256) >>> 9;
    if (r > 511)  r = 511;
    if (r < -512) r = -512;
    return r + 512;
  endfunction

  function automatic int sx10(bit [9:0] v);
    return v[9] ? int'(v) - 1024 : int'(v);
  endfunction

  task automatic check(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    bit run;
    run = 1'b1;
    if (rst) begin
      m_f0 = '0; m_f1 = '0; m_acc = '0; m_poff = 0; m_i = 0; m_q = 0;
      m_am = 0; m_csl = 0; m_a = 512; m_b = 512; m_c = 512; settle = 0;
    end else begin
      run = !(sleep_pin || m_csl);
      if (run) begin
        m_c = m_b; m_b = m_a; m_a = expect_code(m_acc);
        m_acc = m_acc + (fsel ? m_f1 : m_f0);
        if (settle > 0) settle--;
      end else m_c = 512;
      if (ld_freq0) m_f0 = ld_data;
      if (ld_freq1) m_f1 = ld_data;
      if (ld_phase) m_poff = int'(ld_data[11:0]);
      if (ld_iq) begin
        m_i = sx10(ld_data[9:0]); m_q = sx10(ld_data[19:10]); settle = 3;
      end
      if (ld_cmd) begin
        m_am = ld_data[0]; m_csl = ld_data[1]; settle = 3;
      end
    end
    @(posedge clk);
    @(negedge clk);
    {ld_freq0, ld_freq1, ld_phase, ld_iq, ld_cmd} = '0;
    if (settle == 0 || !run) check(tag, int'(dac_code), m_c);
  endtask

  // which: 0 freq0, 1 freq1, 2 phase, 3 iq, 4 cmd
  task automatic load(int which, bit [31:0] d, string tag);
    ld_data = d;
    case (which)
      0: ld_freq0 = 1'b1;
      1: ld_freq1 = 1'b1;
      2: ld_phase = 1'b1;
      3: ld_iq    = 1'b1;
      default: ld_cmd = 1'b1;
    endcase
    tick(tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1; sleep_pin = 1'b0; fsel = 1'b0; ld_data = '0;
    {ld_freq0, ld_freq1, ld_phase, ld_iq, ld_cmd} = '0;
    @(negedge clk);
    repeat (3) tick("R9");
    rst = 1'b0;

    // R7 single word, latency through the pipeline
    load(0, 32'h0123_4567, "R2");
    repeat (40) tick("R7");

    // R1 per-cycle selection between two words
    load(1, $urandom, "R2");
    repeat (300) begin fsel = $urandom % 2; tick("R1"); end

    // R3 / R4 phase offsets over the full circle
    for (int k = 0; k < 5; k++) begin
      load(2, $urandom, "R3");
      repeat (60) begin fsel = $urandom % 2; tick("R4"); end
    end

    // R5: I and Q loaded but modulation disabled
    load(3, $urandom, "R5");
    repeat (60) begin fsel = $urandom % 2; tick("R5"); end

    // R6 modulation with random factors
    load(4, 32'h1, "R6");
    load(3, $urandom, "R6");
    for (int k = 0; k < 400; k++) begin
      fsel = $urandom % 2;
      if (k % 50 == 49) load(3, $urandom, "R6");
      else tick("R6");
    end

    // R8 pin sleep, random
    repeat (200) begin
      sleep_pin = ($urandom % 10) < 3;
      fsel = $urandom % 2;
      tick("R8");
    end
    sleep_pin = 1'b0;

    // R8 command sleep, with R2 loads made while asleep
    load(4, 32'h3, "R8");
    repeat (5) tick("R8");
    load(0, $urandom, "R2");
    load(1, $urandom, "R2");
    repeat (5) tick("R8");
    load(4, 32'h1, "R2");
    repeat (40) begin fsel = $urandom % 2; tick("R2"); end

    // R9 reset in the middle of a run, load attempt ignored
    rst = 1'b1;
    ld_freq0 = 1'b1; ld_data = 32'hFFFF_0000;
    tick("R9");
    tick("R9");
    rst = 1'b0;
    repeat (10) tick("R9");
    check("R9", int'(dac_code), 1023);

    // R10 saturation at 45 degrees, accumulator parked at zero
    load(2, 32'd512, "R10");
    load(4, 32'h1, "R10");
    load(3, (32'd511 << 10) | 32'd511, "R10");
    repeat (4) tick("R10");
    check("R10", int'(dac_code), 1023);
    load(3, (32'h200 << 10) | 32'h200, "R10");
    repeat (4) tick("R10");
    check("R10", int'(dac_code), 0);

    summary();
    $finish;
  end
endmodule